// File: doc/BRIEF.md
# Idle Wake-Up Sequencing Controller

This block decides when a processor core and its clock domain leave a deep idle state in which the crystal oscillator has been switched off. The core asks to idle the clock domain through a single request input. The request is refused while the external parallel bus serves a host port, unless a host-idle override input is also set. Once the domain is idle, any of three wake events restarts the oscillator: an external interrupt line (active low), a real-time-clock interrupt, or a bus reset/resume event. A hardware reset always returns the block to the fully awake state at once.

Wake-up has two stages. The clock domain comes back first, and only after both the oscillator-stable and PLL-lock status inputs are high. The core is then woken by a one-cycle pulse, and only when an enabled source still asks for it. Real-time-clock and bus events are remembered from the moment the clock starts to restart. The external line must be held low for a parameterised number of cycles (three by default) once the clock is stable. A shorter hold leaves only the clock domain running, and a fresh low pulse is then needed. The external line passes through a synchronizer whose depth is a parameter (two flops by default).

Top module: `idle_wake_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `cpu_awake`, `clk_on` and `osc_en` are 1 and `cpu_wake` is 0.
- R2: An `idle_req` that is granted in the awake state, or in the clock-only state, drives `osc_en`, `clk_on` and `cpu_awake` to 0 from the next cycle.
- R3: With `host_mode`=1 and `host_ovr`=0, `idle_req` has no effect: `cpu_awake` and `clk_on` stay 1.
- R4: With `host_mode`=1 and `host_ovr`=1, `idle_req` is granted as in R2.
- R5: While the clock domain is idle, any wake event (`ext_int_n` low, `rtc_evt` high or `bus_evt` high) sets `osc_en` to 1, whatever `int_en` holds. `clk_on` stays 0 until R6 is met.
- R6: `clk_on` rises only in the cycle after one in which `osc_stable` and `pll_lock` were both 1.
- R7: `int_en` bit 0 enables the external line, bit 1 the real-time clock and bit 2 the bus event. A wake whose source bit is 0 brings the clock back (`clk_on`=1) but leaves `cpu_awake` at 0, with no `cpu_wake` pulse.
- R8: An enabled `rtc_evt` or `bus_evt` that woke the clock raises `cpu_wake` once the clock is stable, and `cpu_awake` follows.
- R9: Once `clk_on` is 1 in the clock-only state, `ext_int_n` (after the synchronizer) must be low for EXT_HOLD consecutive cycles to wake the core when bit 0 is set. A shorter low pulse leaves only the clock running, and a later, long enough low pulse then wakes the core.
- R10: `cpu_wake` is high for exactly one cycle, and `cpu_awake` is 1 in the cycle after it.
- R11: A `rtc_evt` or `bus_evt` that arrives while the oscillator is restarting is remembered, and it wakes the core once the clock is stable if its bit is enabled.
- R12: Asserting `rst_n` while the oscillator is restarting returns the block to the awake state at once, with `osc_stable` and `pll_lock` still 0.
- R13: `rtc_evt` and `bus_evt` pulses seen while fully awake are not remembered: they cannot wake the core after a later idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| idle_req | input | 1 | Request to idle the clock domain |
| host_mode | input | 1 | External bus is serving a host port |
| host_ovr | input | 1 | Host-idle override, permits idle in host mode |
| int_en | input | 3 | Wake enables: bit0 external, bit1 RTC, bit2 bus |
| ext_int_n | input | 1 | External interrupt line, active low, asynchronous |
| rtc_evt | input | 1 | Real-time-clock interrupt event |
| bus_evt | input | 1 | Bus reset/resume event |
| osc_stable | input | 1 | Oscillator has settled |
| pll_lock | input | 1 | PLL has locked |
| osc_en | output | 1 | Oscillator enable |
| clk_on | output | 1 | Clock domain running and stable |
| cpu_awake | output | 1 | Core fully awake |
| cpu_wake | output | 1 | One-cycle wake pulse to the core |

## Verification
The bench hunts the hold threshold on the external line with low pulses one cycle short of, equal to, and beyond EXT_HOLD. A counter that is off by one, or that is not cleared by a high level, would wake the core on a short pulse or miss a valid one. It raises the oscillator-stable input well before the lock input, which catches a design that lets the clock through on one status bit alone. It injects events during the restart and while fully awake, and it resets in the middle of a restart: a design that drops latched events, keeps stale ones, or waits on the status inputs after reset would leave the core in the wrong state.

// File: rtl/iws_pkg.sv
package iws_pkg;

   typedef enum logic [2:0] {
      WS_AWAKE     = 3'd0,
      WS_DOM_IDLE  = 3'd1,
      WS_OSC_START = 3'd2,
      WS_CLK_ONLY  = 3'd3,
      WS_CPU_WAKE  = 3'd4
   } wake_state_t;

   localparam int SRC_EXT = 0;
   localparam int SRC_RTC = 1;
   localparam int SRC_BUS = 2;
   localparam int NUM_SRC = 3;

endpackage

// File: rtl/iws_sync.sv
module iws_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 0) begin : g_bad_stages
      $error("iws_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else if (STAGES == 1) begin : g_single
      logic ff;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ff <= RST_VAL;
         else        ff <= d;
      end
      assign q = ff;
   end else begin : g_chain
      logic [STAGES-1:0] sr;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sr <= {STAGES{RST_VAL}};
         else        sr <= {sr[STAGES-2:0], d};
      end
      assign q = sr[STAGES-1];
   end

endmodule

// File: rtl/iws_hold_cnt.sv
module iws_hold_cnt #(
   parameter int HOLD = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic window,
   input  logic line_low,
   output logic hold_met
);

   localparam int CW = (HOLD < 2) ? 1 : $clog2(HOLD + 1);
   localparam logic [CW-1:0] CMAX = CW'(HOLD);

   if (HOLD < 1) begin : g_bad_hold
      $error("iws_hold_cnt: HOLD must be at least 1");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!window || !line_low) begin
         cnt <= '0;
      end else if (cnt != CMAX) begin
         cnt <= cnt + 1'b1;
      end
   end

   assign hold_met = (cnt == CMAX);

   // R9: a high line or a closed window always restarts the count
   a_r9_count_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (!window || !line_low) |=> (cnt == '0));

   // R9: the threshold is reached only after a low sample
   a_r9_met_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold_met) |-> $past(line_low && window));

endmodule

// File: rtl/iws_idle_gate.sv
module iws_idle_gate #(
   parameter bit HOST_GUARD = 1'b1
) (
   input  logic req,
   input  logic host_mode,
   input  logic host_ovr,
   output logic grant
);

   if (HOST_GUARD) begin : g_guarded
      assign grant = req & (~host_mode | host_ovr);
   end else begin : g_open
      assign grant = req;
   end

endmodule

// File: rtl/idle_wake_seq.sv
module idle_wake_seq
   import iws_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int EXT_HOLD    = 3,
   parameter bit HOST_GUARD  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               idle_req,
   input  logic               host_mode,
   input  logic               host_ovr,
   input  logic [NUM_SRC-1:0] int_en,
   input  logic               ext_int_n,
   input  logic               rtc_evt,
   input  logic               bus_evt,
   input  logic               osc_stable,
   input  logic               pll_lock,
   output logic               osc_en,
   output logic               clk_on,
   output logic               cpu_awake,
   output logic               cpu_wake
);

   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("idle_wake_seq: SYNC_STAGES must be 0..4");
   end
   if (EXT_HOLD < 1) begin : g_bad_hold
      $error("idle_wake_seq: EXT_HOLD must be at least 1");
   end

   wake_state_t state, state_nx;
   logic        ext_sync;
   logic        ext_low;
   logic        grant;
   logic        hold_met;
   logic        any_evt;
   logic        clk_ready;
   logic        cpu_go;
   logic        pend_rtc, pend_bus;
   logic        pend_rtc_nx, pend_bus_nx;
   logic        in_sleep;

   iws_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ext_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (ext_int_n),
      .q     (ext_sync)
   );

   assign ext_low = ~ext_sync;

   iws_idle_gate #(.HOST_GUARD(HOST_GUARD)) u_gate (
      .req       (idle_req),
      .host_mode (host_mode),
      .host_ovr  (host_ovr),
      .grant     (grant)
   );

   iws_hold_cnt #(.HOLD(EXT_HOLD)) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .window   (state == WS_CLK_ONLY),
      .line_low (ext_low),
      .hold_met (hold_met)
   );

   assign any_evt   = ext_low | rtc_evt | bus_evt;
   assign clk_ready = osc_stable & pll_lock;
   assign cpu_go    = (pend_rtc & int_en[SRC_RTC])
                    | (pend_bus & int_en[SRC_BUS])
                    | (hold_met & int_en[SRC_EXT]);
   assign in_sleep  = (state == WS_DOM_IDLE) || (state == WS_OSC_START)
                    || (state == WS_CLK_ONLY);

   always_comb begin
      state_nx = state;
      unique case (state)
         WS_AWAKE:     if (grant)     state_nx = WS_DOM_IDLE;
         WS_DOM_IDLE:  if (any_evt)   state_nx = WS_OSC_START;
         WS_OSC_START: if (clk_ready) state_nx = WS_CLK_ONLY;
         WS_CLK_ONLY: begin
            if (cpu_go)     state_nx = WS_CPU_WAKE;
            else if (grant) state_nx = WS_DOM_IDLE;
         end
         WS_CPU_WAKE:  state_nx = WS_AWAKE;
         default:      state_nx = WS_AWAKE;
      endcase
   end

   always_comb begin
      pend_rtc_nx = 1'b0;
      pend_bus_nx = 1'b0;
      if (in_sleep && !(state == WS_CLK_ONLY && grant && !cpu_go)) begin
         pend_rtc_nx = pend_rtc | rtc_evt;
         pend_bus_nx = pend_bus | bus_evt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= WS_AWAKE;
         pend_rtc <= 1'b0;
         pend_bus <= 1'b0;
      end else begin
         state    <= state_nx;
         pend_rtc <= pend_rtc_nx;
         pend_bus <= pend_bus_nx;
      end
   end

   assign osc_en    = (state != WS_DOM_IDLE);
   assign clk_on    = (state == WS_AWAKE) || (state == WS_CLK_ONLY)
                    || (state == WS_CPU_WAKE);
   assign cpu_awake = (state == WS_AWAKE);
   assign cpu_wake  = (state == WS_CPU_WAKE);

   // R2 / R4: a granted request from the awake state idles the domain
   a_r2_idle_enter: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_awake && idle_req && (!host_mode || host_ovr || !HOST_GUARD))
      |=> (!osc_en && !clk_on));

   if (HOST_GUARD) begin : g_host_chk
      // R3: host-port mode without override keeps the domain running
      a_r3_host_block: assert property (@(posedge clk) disable iff (!rst_n)
         (cpu_awake && idle_req && host_mode && !host_ovr) |=> cpu_awake);
   end

   // R5: a timer or bus event in the idle domain restarts the oscillator
   a_r5_osc_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (!osc_en && (rtc_evt || bus_evt)) |=> (osc_en && !clk_on));

   // R6: the clock comes back only after both status inputs were high
   a_r6_lock_gate: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_on) |-> $past(osc_stable && pll_lock));

   // R7: no wake pulse without some enable having been set
   a_r7_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_wake) |-> ($past(int_en) != '0 && $past(clk_on)));

   // R10: single-cycle pulse followed by the awake state
   a_r10_pulse_shape: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_wake |=> (!cpu_wake && cpu_awake));

endmodule

// File: tb/idle_wake_seq_test.sv
`timescale 1ns/1ps
module idle_wake_seq_test;

   localparam int SYNC = 2;
   localparam int HOLD = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       idle_req = 1'b0;
   logic       host_mode = 1'b0;
   logic       host_ovr = 1'b0;
   logic [2:0] int_en = 3'b000;
   logic       ext_int_n = 1'b1;
   logic       rtc_evt = 1'b0;
   logic       bus_evt = 1'b0;
   logic       osc_stable = 1'b0;
   logic       pll_lock = 1'b0;
   logic       osc_en, clk_on, cpu_awake, cpu_wake;

   int checks = 0;
   int errors = 0;
   int pulses = 0;
   int doubles = 0;
   bit done = 1'b0;
   logic prev_wake = 1'b0;

   always #2.5 clk = ~clk;

   idle_wake_seq #(.SYNC_STAGES(SYNC), .EXT_HOLD(HOLD), .HOST_GUARD(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .host_mode(host_mode),
      .host_ovr(host_ovr), .int_en(int_en), .ext_int_n(ext_int_n),
      .rtc_evt(rtc_evt), .bus_evt(bus_evt), .osc_stable(osc_stable),
      .pll_lock(pll_lock), .osc_en(osc_en), .clk_on(clk_on),
      .cpu_awake(cpu_awake), .cpu_wake(cpu_wake)
   );

   always @(negedge clk) begin
      if (cpu_wake) pulses++;
      if (cpu_wake && prev_wake) doubles++;
      prev_wake = cpu_wake;
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic hw_reset();
      rst_n = 1'b0; osc_stable = 1'b0; pll_lock = 1'b0; idle_req = 1'b0;
      ext_int_n = 1'b1; rtc_evt = 1'b0; bus_evt = 1'b0;
      host_mode = 1'b0; host_ovr = 1'b0;
      step(2);
      rst_n = 1'b1;
      step(1);
      pulses = 0; doubles = 0;
   endtask

   task automatic ext_low(input int n);
      ext_int_n = 1'b0; step(n); ext_int_n = 1'b1;
   endtask

   task automatic fire(input int src);
      if (src == 0) ext_low(2);
      else if (src == 1) begin rtc_evt = 1'b1; step(1); rtc_evt = 1'b0; end
      else begin bus_evt = 1'b1; step(1); bus_evt = 1'b0; end
   endtask

   task automatic go_idle();
      idle_req = 1'b1; step(1); idle_req = 1'b0; step(1);
   endtask

   function automatic int exp_cpu(input int src, input logic [2:0] en,
                                  input int extra, input int len);
      if (src == 0) return (en[0] && len >= HOLD) ? 1 : 0;
      return (en[src] || (extra != 0 && en[extra])) ? 1 : 0;
   endfunction

   task automatic run_trial(input int src, input logic [2:0] en, input logic hp,
                            input logic ovr, input int extra, input int len,
                            input int d1);
      int e;
      hw_reset();
      chk("R1 reset cpu_awake", cpu_awake, 1);
      chk("R1 reset clk_on", clk_on, 1);
      int_en = en; host_mode = hp; host_ovr = ovr;
      go_idle();
      step(1);
      if (hp && !ovr) begin
         chk("R3 host mode refuses idle", cpu_awake & clk_on, 1);
         return;
      end
      chk(hp ? "R4 override idles osc" : "R2 idle stops osc", osc_en, 0);
      chk("R2 idle clk_on", clk_on, 0);
      fire(src);
      step(SYNC + 2);
      chk("R5 osc restarted", osc_en, 1);
      chk("R5 clock not yet on", clk_on, 0);
      if (extra != 0) fire(extra);
      osc_stable = 1'b1;
      step(d1);
      chk("R6 no clock without lock", clk_on, 0);
      pll_lock = 1'b1;
      step(3);
      chk("R6 clock on after lock", clk_on, 1);
      if (src == 0) begin
         step(4);
         ext_low(len);
      end
      step(SYNC + 8);
      e = exp_cpu(src, en, extra, len);
      chk(src == 0 ? "R9 ext hold decides wake" : "R8 R11 event wake", cpu_awake, e);
      chk("R7 R10 wake pulse count", pulses, e);
      chk("R10 no double pulse", doubles, 0);
      if (e == 0) chk("R7 clock-only wake", clk_on, 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20250611));
      // R1: values during reset
      step(1);
      chk("R1 in reset cpu_awake", cpu_awake, 1);
      chk("R1 in reset osc_en", osc_en, 1);
      chk("R1 in reset cpu_wake", cpu_wake, 0);

      // directed: threshold sweep on external line (R9)
      run_trial(0, 3'b001, 1'b0, 1'b0, 0, HOLD - 1, 2);
      run_trial(0, 3'b001, 1'b0, 1'b0, 0, HOLD, 2);
      run_trial(0, 3'b001, 1'b0, 1'b0, 0, HOLD + 2, 3);
      run_trial(0, 3'b110, 1'b0, 1'b0, 0, HOLD + 2, 1);   // R7 disabled ext
      run_trial(1, 3'b100, 1'b1, 1'b1, 0, 0, 2);          // R4, R7 rtc disabled
      run_trial(1, 3'b011, 1'b1, 1'b0, 0, 0, 2);          // R3
      run_trial(1, 3'b100, 1'b0, 1'b0, 2, 0, 4);          // R11 latched bus

      // R9: line held low through stabilization, then long enough
      hw_reset();
      int_en = 3'b001;
      go_idle();
      ext_int_n = 1'b0;
      step(SYNC + 3);
      osc_stable = 1'b1; pll_lock = 1'b1;
      step(HOLD + 4);
      ext_int_n = 1'b1;
      step(4);
      chk("R9 continuous low wakes", cpu_awake, 1);

      // R9: short pulse then later valid pulse
      hw_reset();
      int_en = 3'b001;
      go_idle();
      fire(0);
      step(SYNC + 2);
      osc_stable = 1'b1; pll_lock = 1'b1;
      step(3);
      ext_low(HOLD - 1);
      step(SYNC + 4);
      chk("R9 short pulse clock only", cpu_awake, 0);
      chk("R9 short pulse clock on", clk_on, 1);
      // R2: re-idle from clock-only state
      go_idle();
      chk("R2 re-idle from clock-only", osc_en, 0);
      fire(1);
      step(3);
      ext_low(HOLD + 1);
      step(SYNC + 4);
      chk("R9 later pulse wakes", cpu_awake, 1);

      // R12: reset during oscillator restart
      hw_reset();
      int_en = 3'b111;
      go_idle();
      fire(2);
      step(2);
      chk("R12 restarting", cpu_awake, 0);
      rst_n = 1'b0;
      #1;
      chk("R12 reset forces awake", cpu_awake, 1);
      chk("R12 reset forces osc", osc_en, 1);
      step(1);
      rst_n = 1'b1;
      step(1);
      chk("R12 awake after release without lock", cpu_awake & clk_on, 1);

      // R13: events while awake are forgotten
      hw_reset();
      int_en = 3'b010;
      fire(1);
      step(2);
      go_idle();
      fire(2);
      step(2);
      osc_stable = 1'b1; pll_lock = 1'b1;
      step(8);
      chk("R13 stale rtc ignored", cpu_awake, 0);
      chk("R13 clock still on", clk_on, 1);

      // constrained random trials
      for (int t = 0; t < 40; t++) begin
         int src, extra, len, d1;
         logic [2:0] en;
         logic hp, ovr;
         src = $urandom_range(0, 2);
         en = 3'($urandom_range(0, 7));
         hp = ($urandom_range(0, 3) == 0);
         ovr = 1'($urandom_range(0, 1));
         extra = 0;
         if (src != 0 && $urandom_range(0, 1) == 1) extra = (src == 1) ? 2 : 1;
         len = $urandom_range(1, HOLD + 2);
         d1 = $urandom_range(1, 4);
         run_trial(src, en, hp, ovr, extra, len, d1);
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule